// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time as six packed-BCD fields: seconds, minutes, hours (24-hour), day of month, month and a two-digit year. A one-cycle enable pulse, arriving once per second from an external divider, advances the count. Carries ripple from seconds up to years. The day field wraps according to the length of the current month, and February gains a 29th day in leap years.

Software reaches the block through a small byte-wide register window. Six consecutive offsets hold the time fields, followed by a control register and a status register. To set the clock, software stops it, writes the fields and starts it again. To read a coherent time, software latches the live fields into a shadow copy and then points reads at that copy. On each advance the block also emits one-cycle pulses for seconds, minutes, hours and days, and keeps sticky versions of them in the status register.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. Control and status both read 0x00.
- R2: Offsets 0..5 read seconds, minutes, hours, day, month and year in packed BCD (tens digit in bits 7:4). Offset 6 is control and offset 7 is status. Reads are combinational from the address.
- R3: Control bit 0 is the run bit. While it is 1, each cycle with `tick_1hz` high adds one second. While it is 0, ticks leave all fields unchanged.
- R4: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. Each wrap carries one into the next field.
- R5: Day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 31 for the other months except February; 28 for February, or 29 when the year is divisible by four. The wrap carries into the month.
- R6: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: A write to offsets 0..5 while the run bit is 0 loads that byte into the live field. While the run bit is 1, such a write has no effect.
- R8: Writing control with bit 6 set copies all six live fields, as they were before that edge, into the shadow latches. Bit 6 always reads back as 0.
- R9: Control bit 7 selects the source for reads at offsets 0..5: 1 returns the shadow latches and 0 returns the live fields.
- R10: In the cycle after an advancing tick, `ev_sec` is high. `ev_min` is also high if seconds wrapped, `ev_hour` if minutes wrapped as well, and `ev_day` if hours wrapped as well. Each pulse lasts one cycle.
- R11: Status bit 1 mirrors the run bit. Bits 2, 3, 4 and 5 are sticky flags for the second, minute, hour and day events. Writing 1 to a flag bit at offset 7 clears that flag. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_sec | output | 1 | Second event pulse |
| ev_min | output | 1 | Minute event pulse |
| ev_hour | output | 1 | Hour event pulse |
| ev_day | output | 1 | Day event pulse |

## Verification
The in-line assertions check, on every cycle, the properties that can be stated locally. A stopped clock with no field write keeps every field stable. A snapshot equals the live time of the previous cycle. A minute pulse always comes with a second pulse and a zero seconds field, and the same pattern holds for the day and hour pulses. A stepped field always changes value. The calendar rules need the bench's scenarios: month lengths, the leap-year February, the carry of the year, ignored writes while running, the shadow/live read selection and the clearing of status flags. The bench compares these against its own calendar model, using both directed corner dates and random start times with random runs of ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NUM_FIELDS = 6;
   localparam int DAY_IDX    = 3;
   localparam int MON_IDX    = 4;
   localparam int YEAR_IDX   = 5;

   typedef logic [7:0] bcd8_t;

   function automatic bcd8_t bcd_inc(bcd8_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic int unsigned bcd_to_bin(bcd8_t v);
      return 32'(v[7:4]) * 32'd10 + 32'(v[3:0]);
   endfunction

   function automatic bcd8_t month_len(bcd8_t mon, bcd8_t yr, int unsigned leap_div);
      int unsigned y;
      y = bcd_to_bin(yr);
      case (mon)
         8'h02:                      return ((y % leap_div) == 0) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd8_t field_first(int idx);
      return (idx == DAY_IDX || idx == MON_IDX) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd8_t field_limit(int idx);
      case (idx)
         0, 1:     return 8'h59;
         2:        return 8'h23;
         MON_IDX:  return 8'h12;
         YEAR_IDX: return 8'h99;
         default:  return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
   import cal_pkg::*;
#(
   parameter bcd8_t FIRST = 8'h00
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   input  bcd8_t limit,
   input  logic  load,
   input  bcd8_t load_val,
   output bcd8_t value,
   output logic  wrap
);

   assign wrap = step && (value >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)      value <= FIRST;
      else if (load)   value <= load_val;
      else if (step)   value <= (value >= limit) ? FIRST : bcd_inc(value);
   end

   // a stepped field always moves (R3, R4)
   assert_step_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && limit != FIRST) |=> (value != $past(value)));

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
   import cal_pkg::*;
#(
   parameter int unsigned LEAP_DIV = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    advance,
   input  logic [NUM_FIELDS-1:0]   load_en,
   input  bcd8_t                   load_val,
   output bcd8_t [NUM_FIELDS-1:0]  time_o,
   output logic  [NUM_FIELDS-1:0]  wrap_o
);

   logic  [NUM_FIELDS-1:0] step;
   bcd8_t [NUM_FIELDS-1:0] lim;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      if (i == 0) begin : g_lsb
         assign step[i] = advance;
      end else begin : g_carry
         assign step[i] = wrap_o[i-1];
      end

      if (i == DAY_IDX) begin : g_dyn_lim
         assign lim[i] = month_len(time_o[MON_IDX], time_o[YEAR_IDX], LEAP_DIV);
      end else begin : g_fix_lim
         assign lim[i] = field_limit(i);
      end

      cal_bcd_field #(.FIRST(field_first(i))) u_field (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (step[i]),
         .limit    (lim[i]),
         .load     (load_en[i]),
         .load_val (load_val),
         .value    (time_o[i]),
         .wrap     (wrap_o[i])
      );
   end

   // a day wrap lands on the first day of the next month (R5)
   assert_day_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_o[DAY_IDX] && load_en == '0) |=> (time_o[DAY_IDX] == 8'h01 &&
         time_o[MON_IDX] != $past(time_o[MON_IDX])));

endmodule

// File: rtl/cal_regs.sv
module cal_regs
   import cal_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int CTRL_ADDR = 6,
   parameter int STAT_ADDR = 7
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  bcd8_t                   wdata,
   input  bcd8_t [NUM_FIELDS-1:0]  live,
   input  logic  [3:0]             events,
   output logic                    run,
   output logic  [NUM_FIELDS-1:0]  load_en,
   output bcd8_t                   rdata
);

   localparam int RUN_BIT  = 0;
   localparam int SNAP_BIT = 6;
   localparam int SEL_BIT  = 7;

   logic                   sel_shadow;
   logic [3:0]             flags;
   bcd8_t [NUM_FIELDS-1:0] shadow;
   logic                   ctrl_wr, stat_wr, snap;

   assign ctrl_wr = we && (addr == ADDR_W'(CTRL_ADDR));
   assign stat_wr = we && (addr == ADDR_W'(STAT_ADDR));
   assign snap    = ctrl_wr && wdata[SNAP_BIT];

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_load
      assign load_en[i] = we && !run && (addr == ADDR_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run        <= 1'b0;
         sel_shadow <= 1'b0;
      end else if (ctrl_wr) begin
         run        <= wdata[RUN_BIT];
         sel_shadow <= wdata[SEL_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FIELDS; i++) shadow[i] <= field_first(i);
      end else if (snap) begin
         shadow <= live;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  flags <= 4'h0;
      else         flags <= (flags & ~(stat_wr ? wdata[5:2] : 4'h0)) | events;
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (addr == ADDR_W'(i)) rdata = sel_shadow ? shadow[i] : live[i];
      end
      if (addr == ADDR_W'(CTRL_ADDR)) rdata = {sel_shadow, 6'b0, run};
      if (addr == ADDR_W'(STAT_ADDR)) rdata = {2'b00, flags, run, 1'b0};
   end

   // snapshot captures the live time of the write cycle (R8)
   assert_snapshot_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (shadow == $past(live)));

   // no field load while running (R7)
   assert_no_load_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (load_en == '0));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import cal_pkg::*;
#(
   parameter int          ADDR_W    = 3,
   parameter int          CTRL_ADDR = 6,
   parameter int          STAT_ADDR = 7,
   parameter int unsigned LEAP_DIV  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              ev_sec,
   output logic              ev_min,
   output logic              ev_hour,
   output logic              ev_day
);

   localparam int MAP_SIZE = 1 << ADDR_W;

   if (MAP_SIZE < NUM_FIELDS + 2) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end
   if (CTRL_ADDR < NUM_FIELDS || STAT_ADDR < NUM_FIELDS ||
       CTRL_ADDR == STAT_ADDR || CTRL_ADDR >= MAP_SIZE || STAT_ADDR >= MAP_SIZE) begin : g_chk_map
      $error("control/status offsets overlap the time fields or leave the map");
   end
   if (LEAP_DIV == 0) begin : g_chk_leap
      $error("LEAP_DIV must be nonzero");
   end

   logic                   run, advance;
   logic  [NUM_FIELDS-1:0] load_en, wrap;
   bcd8_t [NUM_FIELDS-1:0] live;
   logic  [3:0]            ev_q;

   assign advance = tick_1hz && run;

   cal_time_chain #(.LEAP_DIV(LEAP_DIV)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .load_en  (load_en),
      .load_val (reg_wdata),
      .time_o   (live),
      .wrap_o   (wrap)
   );

   cal_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .live    (live),
      .events  (ev_q),
      .run     (run),
      .load_en (load_en),
      .rdata   (reg_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ev_q <= 4'h0;
      else        ev_q <= {wrap[2], wrap[1], wrap[0], advance};
   end

   assign ev_sec  = ev_q[0];
   assign ev_min  = ev_q[1];
   assign ev_hour = ev_q[2];
   assign ev_day  = ev_q[3];

   // stopped and unwritten: time frozen (R3)
   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(reg_we && reg_addr < ADDR_W'(NUM_FIELDS))) |=> $stable(live));

   // minute pulse implies second pulse with seconds at zero (R10, R4)
   assert_min_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_min |-> (ev_sec && live[0] == 8'h00));

   // day pulse implies hour pulse with hours at zero (R10, R4)
   assert_day_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_day |-> (ev_hour && live[2] == 8'h00));

endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       ev_sec, ev_min, ev_hour, ev_day;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int m [6];

   always #2.5 clk = ~clk;

   bcd_calendar_clock u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_sec(ev_sec), .ev_min(ev_min), .ev_hour(ev_hour), .ev_day(ev_day)
   );

   function automatic logic [7:0] to_bcd(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int dim(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic do_tick(output logic [3:0] ev);
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      ev = {ev_day, ev_hour, ev_min, ev_sec};
   endtask

   task automatic model_tick(output logic [3:0] ev);
      ev = 4'b0001;
      m[0]++;
      if (m[0] == 60) begin
         m[0] = 0; ev[1] = 1; m[1]++;
         if (m[1] == 60) begin
            m[1] = 0; ev[2] = 1; m[2]++;
            if (m[2] == 24) begin
               m[2] = 0; ev[3] = 1;
               if (m[3] >= dim(m[4], m[5])) begin
                  m[3] = 1; m[4]++;
                  if (m[4] == 13) begin m[4] = 1; m[5] = (m[5] + 1) % 100; end
               end else m[3]++;
            end
         end
      end
   endtask

   task automatic check_time(string req);
      logic [7:0] d;
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), d);
         chk(req, d, to_bcd(m[i]));
      end
   endtask

   task automatic load_time(int s, int mi, int h, int dd, int mo, int y);
      wr(3'd6, 8'h00);
      wr(3'd0, to_bcd(s)); wr(3'd1, to_bcd(mi)); wr(3'd2, to_bcd(h));
      wr(3'd3, to_bcd(dd)); wr(3'd4, to_bcd(mo)); wr(3'd5, to_bcd(y));
      m[0] = s; m[1] = mi; m[2] = h; m[3] = dd; m[4] = mo; m[5] = y;
   endtask

   task automatic tick_and_check(string req);
      logic [3:0] ev, exp_ev;
      model_tick(exp_ev);
      do_tick(ev);
      chk({req, " R10 events"}, ev, exp_ev);
      check_time(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [3:0] ev;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 1; m[5] = 0;
      check_time("R1 reset time");
      rd(3'd6, d); chk("R1 ctrl reset", d, 8'h00);
      rd(3'd7, d); chk("R1 status reset", d, 8'h00);

      // R3 stopped: tick has no effect
      do_tick(ev);
      chk("R3 no events while stopped", ev, 4'h0);
      check_time("R3 hold while stopped");

      // R3 run, R10 pulse width
      wr(3'd6, 8'h01);
      tick_and_check("R3 advance");
      @(negedge clk);
      chk("R10 pulse lasts one cycle", {ev_day, ev_hour, ev_min, ev_sec}, 4'h0);

      // R7 writes ignored while running
      wr(3'd0, 8'h45);
      check_time("R7 write ignored when running");

      // R4 R6 full rollover, R11 status
      load_time(59, 59, 23, 31, 12, 99);
      check_time("R7 load when stopped");
      rd(3'd7, d); chk("R11 run flag clear", d[1], 0);
      wr(3'd7, 8'h3C);
      wr(3'd6, 8'h01);
      tick_and_check("R6 year wrap R4");
      rd(3'd7, d); chk("R11 status all flags", d, 8'h3E);
      wr(3'd7, 8'h24);
      rd(3'd7, d); chk("R11 partial clear", d, 8'h1A);
      wr(3'd7, 8'h18);
      rd(3'd7, d); chk("R11 cleared", d, 8'h02);

      // R5 month lengths and leap years
      load_time(59, 59, 23, 28, 2, 4);  wr(3'd6, 8'h01); tick_and_check("R5 leap feb 28->29");
      load_time(59, 59, 23, 29, 2, 4);  wr(3'd6, 8'h01); tick_and_check("R5 leap feb 29->mar");
      load_time(59, 59, 23, 28, 2, 3);  wr(3'd6, 8'h01); tick_and_check("R5 feb 28->mar");
      load_time(59, 59, 23, 30, 4, 50); wr(3'd6, 8'h01); tick_and_check("R5 apr 30->may");
      load_time(59, 59, 23, 30, 1, 7);  wr(3'd6, 8'h01); tick_and_check("R5 jan 30->31");
      load_time(59, 59, 23, 31, 1, 7);  wr(3'd6, 8'h01); tick_and_check("R5 jan 31->feb");
      load_time(59, 59, 23, 30, 11, 0); wr(3'd6, 8'h01); tick_and_check("R5 nov 30->dec");
      load_time(59, 59, 22, 31, 12, 41); wr(3'd6, 8'h01); tick_and_check("R4 hour carry");
      load_time(9, 0, 0, 1, 1, 0);      wr(3'd6, 8'h01); tick_and_check("R2 bcd digit carry");

      // R8 R9 snapshot and read source
      load_time(12, 34, 5, 17, 8, 21);
      wr(3'd6, 8'h41);
      for (int k = 0; k < 3; k++) model_tick(ev);
      for (int k = 0; k < 3; k++) do_tick(ev);
      wr(3'd6, 8'h81);
      rd(3'd6, d); chk("R8 snap bit reads 0", d, 8'h81);
      rd(3'd0, d); chk("R9 shadow seconds", d, 8'h12);
      rd(3'd1, d); chk("R9 shadow minutes", d, 8'h34);
      rd(3'd5, d); chk("R9 shadow year", d, 8'h21);
      wr(3'd6, 8'h01);
      check_time("R9 live after deselect");

      // random starts and runs
      for (int it = 0; it < 40; it++) begin
         int mo, y;
         mo = 1 + int'($urandom_range(11));
         y  = int'($urandom_range(99));
         load_time(int'($urandom_range(59)), 55 + int'($urandom_range(4)),
                   int'($urandom_range(23)), dim(mo, y) - int'($urandom_range(1)), mo, y);
         if (it % 3 == 0) m[0] = 50 + int'($urandom_range(9));
         wr(3'd0, to_bcd(m[0]));
         wr(3'd6, 8'h01);
         for (int k = 0, n = 1 + int'($urandom_range(12)); k < n; k++) begin
            repeat (int'($urandom_range(3))) @(negedge clk);
            tick_and_check("R3 random run");
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule